// File: doc/BRIEF.md
# Circular-Space Copy Overlap Detector

This block judges whether a forward, byte-by-byte copy from a source region into a destination region could overwrite source bytes before they are read. Addresses live in a circular space of `2^ADDR_W` bytes, so a region running past the top address continues at zero. The block takes the start address and length of each region and reports one overlap flag. It also reports the address of the last source byte that the copy would touch, which helps when debugging.

Only the shorter of the two lengths matters, because the copy stops when either region runs out. The source extent is classed as empty, single-byte, flat or wrapping, and each class has its own safety rule. A request strobe samples the operands. The verdict appears on registered outputs one clock later, together with a matching valid pulse, and stays there until the next request.

Top module: `ovl_detect`

## Requirements
- R1: The effective length is the smaller of `dst_len_i` and `src_len_i`. `last_o` equals `src_addr_i + effective length - 1`, taken modulo `2^ADDR_W`. With an effective length of zero this is `src_addr_i - 1` modulo `2^ADDR_W`.
- R2: For a flat (non-wrapping) source with an effective length of at least 2, `ovl_o` is 0 when `dst_addr_i <= src_addr_i`.
- R3: For a flat source with an effective length of at least 2, `ovl_o` is 0 when `dst_addr_i > last_o`. `ovl_o` is 1 when `src_addr_i < dst_addr_i <= last_o`.
- R4: The source wraps when `src_addr_i + effective length - 1`, formed in `ADDR_W+1` bits, exceeds `2^ADDR_W - 1`. For a wrapping source, `ovl_o` is 0 only when `dst_addr_i <= src_addr_i` and also `dst_addr_i > last_o`. Otherwise it is 1.
- R5: When the effective length is 0 or 1, including any case where `dst_len_i` is 0, `ovl_o` is 0.
- R6: `valid_o` is 1 in exactly the cycle after a cycle in which `valid_i` was 1. `ovl_o` and `last_o` reflect the operands sampled with that strobe. They hold their values while `valid_i` stays 0.
- R7: While `rst_ni` is low, `valid_o`, `ovl_o` and `last_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; operands are sampled on this edge |
| dst_addr_i | input | ADDR_W | Destination start address |
| dst_len_i | input | ADDR_W | Destination length in bytes |
| src_addr_i | input | ADDR_W | Source start address |
| src_len_i | input | ADDR_W | Source length in bytes |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| ovl_o | output | 1 | Destructive overlap detected |
| last_o | output | ADDR_W | Last participating source byte address |

## Verification
The bench builds the block with the default `ADDR_W` of 24. This lets it place operands at the real top address 0xFFFFFF and cross into zero. It compares a source that ends exactly at the top address, which is flat, with one that ends a single byte later, which wraps. The same destination at address zero is safe in the first case and unsafe in the second. Unequal length pairs show that the shorter length sets the extent. Gaps between requests show that the registered verdict is held.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned DEF_ADDR_W = 24;

  typedef enum logic [1:0] {
    SPAN_EMPTY  = 2'd0,
    SPAN_SINGLE = 2'd1,
    SPAN_FLAT   = 2'd2,
    SPAN_WRAP   = 2'd3
  } span_kind_e;
endpackage

// File: rtl/ovl_len_min.sv
module ovl_len_min #(
  parameter int unsigned ADDR_W = ovl_pkg::DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] dst_len_i,
  input  logic [ADDR_W-1:0] src_len_i,
  output logic [ADDR_W-1:0] eff_len_o
);
  always_comb begin
    eff_len_o = (dst_len_i < src_len_i) ? dst_len_i : src_len_i;
  end
endmodule

// File: rtl/ovl_extent.sv
module ovl_extent
  import ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] eff_len_i,
  output logic [ADDR_W-1:0] last_o,
  output span_kind_e        kind_o
);
  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] span_end;

  // carry bit of the extended sum marks a crossing of the top address
  assign span_end = {1'b0, src_addr_i} + {1'b0, eff_len_i} - SUM_W'(1);
  assign last_o   = span_end[ADDR_W-1:0];

  always_comb begin
    if (eff_len_i == '0)               kind_o = SPAN_EMPTY;
    else if (eff_len_i == ADDR_W'(1))  kind_o = SPAN_SINGLE;
    else if (span_end[ADDR_W])         kind_o = SPAN_WRAP;
    else                               kind_o = SPAN_FLAT;
  end
endmodule

// File: rtl/ovl_decide.sv
module ovl_decide
  import ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] last_i,
  input  span_kind_e        kind_i,
  output logic              ovl_o
);
  logic at_or_below;
  logic past_end;
  logic safe;

  assign at_or_below = (dst_addr_i <= src_addr_i);
  assign past_end    = (dst_addr_i > last_i);

  always_comb begin
    unique case (kind_i)
      SPAN_FLAT: safe = at_or_below | past_end;
      SPAN_WRAP: safe = at_or_below & past_end;
      default:   safe = 1'b1;
    endcase
  end

  assign ovl_o = ~safe;
endmodule

// File: rtl/ovl_detect.sv
module ovl_detect
  import ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] dst_len_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] src_len_i,
  output logic              valid_o,
  output logic              ovl_o,
  output logic [ADDR_W-1:0] last_o
);
  logic [ADDR_W-1:0] eff_len;
  logic [ADDR_W-1:0] last_d;
  span_kind_e        kind;
  logic              ovl_d;

  ovl_len_min #(.ADDR_W(ADDR_W)) u_min (
    .dst_len_i (dst_len_i),
    .src_len_i (src_len_i),
    .eff_len_o (eff_len)
  );

  ovl_extent #(.ADDR_W(ADDR_W)) u_ext (
    .src_addr_i (src_addr_i),
    .eff_len_i  (eff_len),
    .last_o     (last_d),
    .kind_o     (kind)
  );

  ovl_decide #(.ADDR_W(ADDR_W)) u_dec (
    .dst_addr_i (dst_addr_i),
    .src_addr_i (src_addr_i),
    .last_i     (last_d),
    .kind_i     (kind),
    .ovl_o      (ovl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovl_o   <= 1'b0;
      last_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ovl_o  <= ovl_d;
        last_o <= last_d;
      end
    end
  end
endmodule

// File: rtl/ovl_detect_chk.sv
module ovl_detect_chk #(
  parameter int unsigned ADDR_W = ovl_pkg::DEF_ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] dst_addr_i,
  input logic [ADDR_W-1:0] dst_len_i,
  input logic [ADDR_W-1:0] src_addr_i,
  input logic [ADDR_W-1:0] src_len_i,
  input logic              valid_o,
  input logic              ovl_o,
  input logic [ADDR_W-1:0] last_o
);
  logic [ADDR_W-1:0] src_next;
  logic [ADDR_W-1:0] equal_len_end;
  logic              short_req;

  assign src_next      = src_addr_i + ADDR_W'(1);
  assign equal_len_end = src_addr_i + src_len_i - ADDR_W'(1);
  assign short_req     = (dst_len_i < ADDR_W'(2)) || (src_len_i < ADDR_W'(2));

  assert_valid_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ovl_o) && $stable(last_o)));

  assert_short_safe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && short_req) |=> !ovl_o);

  assert_same_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dst_addr_i == src_addr_i) |=> !ovl_o);

  assert_next_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !short_req && dst_addr_i == src_next) |=> ovl_o);

  assert_equal_len_end_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dst_len_i == src_len_i) |=> (last_o == $past(equal_len_end)));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R7: assert (!valid_o && !ovl_o && last_o == '0);
    end
  end
endmodule

bind ovl_detect ovl_detect_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ovl_detect_tb.sv
module ovl_detect_tb_top;
  localparam int unsigned ADDR_W = 24;
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [ADDR_W-1:0] dst_addr_i = '0;
  logic [ADDR_W-1:0] dst_len_i = '0;
  logic [ADDR_W-1:0] src_addr_i = '0;
  logic [ADDR_W-1:0] src_len_i = '0;
  logic              valid_o;
  logic              ovl_o;
  logic [ADDR_W-1:0] last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  ovl_detect #(.ADDR_W(ADDR_W)) dut_i (.*);

  task automatic chk(input string req, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // strobe one request, sample at the following falling edge
  task automatic run(input string req,
                     input logic [ADDR_W-1:0] d, input logic [ADDR_W-1:0] dl,
                     input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] sl,
                     input logic exp_ovl, input logic [ADDR_W-1:0] exp_last);
    @(negedge clk_i);
    dst_addr_i = d; dst_len_i = dl; src_addr_i = s; src_len_i = sl;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, ADDR_W'(valid_o), ADDR_W'(1));
    chk({req, " ovl"}, ADDR_W'(ovl_o), ADDR_W'(exp_ovl));
    chk({req, " last"}, last_o, exp_last);
  endtask

  task automatic t_reset;
    chk("R7 valid", ADDR_W'(valid_o), '0);
    chk("R7 ovl", ADDR_W'(ovl_o), '0);
    chk("R7 last", last_o, '0);
  endtask

  task automatic t_min_len;  // R1
    run("R1 dst shorter", 24'h230, 24'h20, 24'h200, 24'h100, 1'b0, 24'h21F);
    run("R1 src shorter", 24'h230, 24'h100, 24'h200, 24'h20, 1'b0, 24'h21F);
    run("R1 zero eff", 24'h300, 24'h0, 24'h200, 24'h40, 1'b0, 24'h1FF);
  endtask

  task automatic t_flat_below;  // R2
    run("R2 dst below", 24'h100, 24'h80, 24'h200, 24'h80, 1'b0, 24'h27F);
    run("R2 dst equal", 24'h500, 24'h10, 24'h500, 24'h10, 1'b0, 24'h50F);
    run("R2 top flat dst0", 24'h0, 24'h10, 24'hFFFFF0, 24'h10, 1'b0, TOP);
  endtask

  task automatic t_flat_above;  // R3
    run("R3 past end", 24'h300, 24'h100, 24'h200, 24'h100, 1'b0, 24'h2FF);
    run("R3 inside", 24'h250, 24'h100, 24'h200, 24'h100, 1'b1, 24'h2FF);
    run("R3 at end", 24'h2FF, 24'h100, 24'h200, 24'h100, 1'b1, 24'h2FF);
    run("R3 next byte", 24'h201, 24'h2, 24'h200, 24'h2, 1'b1, 24'h201);
    run("R3 top flat inside", 24'hFFFFF8, 24'h10, 24'hFFFFF0, 24'h10, 1'b1, TOP);
  endtask

  task automatic t_wrap;  // R4
    run("R4 safe gap", 24'h10, 24'h20, 24'hFFFFF0, 24'h20, 1'b0, 24'h0F);
    run("R4 on end", 24'h0F, 24'h20, 24'hFFFFF0, 24'h20, 1'b1, 24'h0F);
    run("R4 low part", 24'h05, 24'h20, 24'hFFFFF0, 24'h20, 1'b1, 24'h0F);
    run("R4 high part", 24'hFFFFF8, 24'h20, 24'hFFFFF0, 24'h20, 1'b1, 24'h0F);
    run("R4 same start", 24'hFFFFF0, 24'h20, 24'hFFFFF0, 24'h20, 1'b0, 24'h0F);
    run("R4 one past top dst0", 24'h0, 24'h11, 24'hFFFFF0, 24'h11, 1'b1, 24'h0);
  endtask

  task automatic t_short;  // R5
    run("R5 dst len 0", 24'h201, 24'h0, 24'h200, 24'h100, 1'b0, 24'h1FF);
    run("R5 dst len 1", 24'h201, 24'h1, 24'h200, 24'h100, 1'b0, 24'h200);
    run("R5 src len 1", 24'h200, 24'h5, 24'h200, 24'h1, 1'b0, 24'h200);
    run("R5 src len 0", 24'h201, 24'h5, 24'h200, 24'h0, 1'b0, 24'h1FF);
    run("R5 single at top", 24'h0, 24'h8, TOP, 24'h1, 1'b0, TOP);
  endtask

  task automatic t_hold;  // R6
    run("R6 setup", 24'h250, 24'h100, 24'h200, 24'h100, 1'b1, 24'h2FF);
    @(negedge clk_i);
    dst_addr_i = 24'h0; src_addr_i = 24'h900; dst_len_i = 24'h0; src_len_i = 24'h0;
    @(negedge clk_i);
    chk("R6 idle valid", ADDR_W'(valid_o), '0);
    chk("R6 held ovl", ADDR_W'(ovl_o), ADDR_W'(1));
    chk("R6 held last", last_o, 24'h2FF);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_min_len();
    t_flat_below();
    t_flat_above();
    t_wrap();
    t_short();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule